// File: doc/BRIEF.md
# Mu-law Sample Compander

This block converts between 8-bit mu-law codes and signed 16-bit linear PCM samples. It has two independent paths that share one clock. The expander path takes a code byte and returns a linear sample. The compressor path takes a linear sample and returns a code byte. Both paths can accept an input in the same cycle, and each returns its result one cycle later with its own valid flag.

The linear side is four times the 14-bit mu-law range. On the way out, the expander multiplies its result by four. On the way in, the compressor first shifts the sample arithmetically right by two and then applies the bias. A telephony front end can use it to feed compressed voice slots to a line interface and to unpack received slots for processing, one sample per cycle in each direction.

Top module: `mulaw_codec`

## Requirements
- R1: While reset is asserted and after it is released, both output valid flags are 0 and both output values are 0 until the first accepted input.
- R2: Expansion inverts all eight code bits. After inversion, bit 7 is the sign, bits 6:4 are the segment s and bits 3:0 are the step q. The magnitude is ((2q+33) shifted left by s) - 33, and it is negated when the sign bit is 1. The output is that value times 4.
- R3: Codes 0xFF and 0x7F both expand to a linear output of 0.
- R4: Compression shifts the sample arithmetically right by 2 and adds 33 to its absolute value to form the biased magnitude. The segment is the position of the leading one of that magnitude minus 5. The step is the four bits just below the leading one. The code's low seven bits are the inverse of {segment, step}.
- R5: A biased magnitude above 8191 saturates {segment, step} to 0x7F. The result is code 0x80 for a non-negative sample and 0x00 for a negative one.
- R6: Code bit 7 is 1 for a non-negative sample and 0 for a negative one.
- R7: A valid input on either path produces its result and a raised output valid flag exactly one clock later.
- R8: When an input valid flag is low, that path's output value holds its previous result and its output valid flag is 0 in the next cycle.
- R9: Both paths operate in the same cycle with no interaction between them.
- R10: Compressing the expansion of any code returns the same code, except code 0x7F, which returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Expander input valid |
| decCode | input | 8 | Mu-law code to expand |
| encValid | input | 1 | Compressor input valid |
| encSample | input | 16 | Signed linear sample to compress |
| decOutValid | output | 1 | Expander result valid |
| decSample | output | 16 | Signed linear result |
| encOutValid | output | 1 | Compressor result valid |
| encCode | output | 8 | Mu-law code result |

## Verification
Expansion and compression can both be accepted in the same clock. The bench therefore runs the sweep of all 65536 linear samples while the expander cycles through all 256 codes in the same cycles. Each path is compared every cycle against arithmetic models built into the bench. A second pass feeds the expected expansion of each code to the compressor while that code is also being expanded, which checks the round trip and the concurrent use together. A final phase drops both valid flags and changes the inputs to show that the results hold.

// File: rtl/mulaw_codec_pkg.sv
package mulaw_codec_pkg;
  localparam int CODE_W   = 8;
  localparam int PCM_W    = 16;
  localparam int SEG_W    = 3;
  localparam int STEP_W   = 4;
  localparam int SCALE_SH = 2;
  localparam int BIAS     = 33;
  localparam int CLIP     = 8191;
  localparam int MAG_W    = PCM_W - SCALE_SH - 1;
  localparam int SEG_N    = 1 << SEG_W;
  localparam int SEG_LSB  = STEP_W + 1;

  typedef struct packed {
    logic decLoad;
    logic encLoad;
  } strobe_t;
endpackage

// File: rtl/mulaw_seg_find.sv
module mulaw_seg_find #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits,
  output logic [IDX_W-1:0] idx
);
  // highest set bit wins: later loop iterations overwrite earlier ones
  always_comb begin
    idx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (bits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mulaw_codec_ctrl.sv
module mulaw_codec_ctrl
  import mulaw_codec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    decValid,
  input  logic    encValid,
  output strobe_t strb,
  output logic    decOutValid,
  output logic    encOutValid
);
  always_comb begin
    strb.decLoad = decValid;
    strb.encLoad = encValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decOutValid <= 1'b0;
      encOutValid <= 1'b0;
    end else begin
      decOutValid <= decValid;
      encOutValid <= encValid;
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> decOutValid); // R7
  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    encValid |=> encOutValid); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> !decOutValid); // R8
endmodule

// File: rtl/mulaw_codec_dp.sv
module mulaw_codec_dp
  import mulaw_codec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CODE_W-1:0] decCode,
  input  logic [PCM_W-1:0]  encSample,
  output logic [PCM_W-1:0]  decSample,
  output logic [CODE_W-1:0] encCode
);
  localparam int SHIFT_W = MAG_W;

  // expander
  logic [CODE_W-1:0]  dInv;
  logic [SEG_W-1:0]   dSeg;
  logic [STEP_W-1:0]  dStep;
  logic [SHIFT_W-1:0] dBase;
  logic [SHIFT_W-1:0] dShift;
  logic [SHIFT_W-1:0] dMag;
  logic [PCM_W-1:0]   dScaled;
  logic [PCM_W-1:0]   dOut;

  always_comb begin
    dInv    = ~decCode;
    dSeg    = dInv[CODE_W-2 -: SEG_W];
    dStep   = dInv[STEP_W-1:0];
    dBase   = SHIFT_W'({1'b1, dStep, 1'b1});
    dShift  = dBase << dSeg;
    dMag    = dShift - SHIFT_W'(BIAS);
    dScaled = PCM_W'({dMag, {SCALE_SH{1'b0}}});
    dOut    = dInv[CODE_W-1] ? PCM_W'(~dScaled + PCM_W'(1)) : dScaled;
  end

  // compressor
  logic                    eNeg;
  logic [PCM_W-1:0]        eShr;
  logic [PCM_W-1:0]        eAbs;
  logic [PCM_W-1:0]        eBiased;
  logic                    eSat;
  logic [SEG_W-1:0]        eSeg;
  logic [PCM_W-1:0]        eSteps;
  logic [CODE_W-2:0]       eIdx;
  logic [CODE_W-1:0]       eOut;

  mulaw_seg_find #(.WIDTH(SEG_N)) uSegFind (
    .bits (eBiased[SEG_LSB +: SEG_N]),
    .idx  (eSeg)
  );

  always_comb begin
    eNeg    = encSample[PCM_W-1];
    eShr    = PCM_W'($signed(encSample) >>> SCALE_SH);
    eAbs    = eNeg ? PCM_W'(~eShr + PCM_W'(1)) : eShr;
    eBiased = eAbs + PCM_W'(BIAS);
    eSat    = eBiased > PCM_W'(CLIP);
    eSteps  = eBiased >> ({1'b0, eSeg} + (SEG_W+1)'(1));
    eIdx    = eSat ? '1 : {eSeg, eSteps[STEP_W-1:0]};
    eOut    = {~eNeg, ~eIdx};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decSample <= '0;
      encCode   <= '0;
    end else begin
      if (strb.decLoad) decSample <= dOut;
      if (strb.encLoad) encCode   <= eOut;
    end
  end

  AST_DEC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.decLoad && (decCode[CODE_W-2:0] == '1) |=> decSample == '0); // R3
  AST_DEC_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    strb.decLoad && !decCode[CODE_W-1] && (decCode[CODE_W-2:0] != '1)
      |=> decSample[PCM_W-1]); // R2
  AST_ENC_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    strb.encLoad |=> encCode[CODE_W-1] == !$past(encSample[PCM_W-1])); // R6
  AST_ENC_SAT: assert property (@(posedge clk) disable iff (!rstN)
    strb.encLoad && (($signed(encSample) >= 16'sd32636) ||
                     ($signed(encSample) <= -16'sd32633))
      |=> encCode[CODE_W-2:0] == '0); // R5
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.decLoad |=> $stable(decSample)); // R8
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.encLoad |=> $stable(encCode)); // R8
endmodule

// File: rtl/mulaw_codec.sv
module mulaw_codec
  import mulaw_codec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        decValid,
  input  logic [7:0]  decCode,
  input  logic        encValid,
  input  logic [15:0] encSample,
  output logic        decOutValid,
  output logic [15:0] decSample,
  output logic        encOutValid,
  output logic [7:0]  encCode
);
  strobe_t strb;

  mulaw_codec_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .decValid    (decValid),
    .encValid    (encValid),
    .strb        (strb),
    .decOutValid (decOutValid),
    .encOutValid (encOutValid)
  );

  mulaw_codec_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .decCode   (decCode),
    .encSample (encSample),
    .decSample (decSample),
    .encCode   (encCode)
  );
endmodule

// File: tb/mulaw_codec_test.sv
module mulaw_codec_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        decValid = 1'b0;
  logic [7:0]  decCode = '0;
  logic        encValid = 1'b0;
  logic [15:0] encSample = '0;
  logic        decOutValid;
  logic [15:0] decSample;
  logic        encOutValid;
  logic [7:0]  encCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mulaw_codec uut (
    .clk(clk), .rstN(rstN),
    .decValid(decValid), .decCode(decCode),
    .encValid(encValid), .encSample(encSample),
    .decOutValid(decOutValid), .decSample(decSample),
    .encOutValid(encOutValid), .encCode(encCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expDec(input logic [7:0] c);
    int t, s, q, mag;
    t = int'(~c) & 255;
    s = (t >> 4) & 7;
    q = t & 15;
    mag = ((2*q + 33) * (1 << s)) - 33;
    if (t >= 128) mag = -mag;
    return 16'(mag * 4);
  endfunction

  function automatic logic [7:0] expEnc(input logic [15:0] x);
    int v, a, s, idx;
    v = int'($signed(x));
    v = (v < 0) ? -((-v + 3) / 4) : v / 4;
    a = ((v < 0) ? -v : v) + 33;
    if (a > 8191) idx = 127;
    else begin
      s = 0;
      while (a >= (64 << s)) s++;
      idx = s * 16 + ((a >> (s + 1)) & 15);
    end
    return {(v >= 0), ~7'(idx)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected <%0d cycles", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] heldDec;
    logic [7:0]  heldEnc;
    repeat (3) @(posedge clk);
    #1;
    check("R1 dec valid", 32'(decOutValid), 0);
    check("R1 enc valid", 32'(encOutValid), 0);
    check("R1 dec value", 32'(decSample), 0);
    check("R1 enc value", 32'(encCode), 0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 idle after reset", {decOutValid, encOutValid, decSample, encCode}, 0);

    // R2 R4 R5 R6 R7 R9: both paths swept together
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      decValid = 1'b1; encValid = 1'b1;
      decCode = 8'(i); encSample = 16'(i);
      @(posedge clk); #1;
      check("R7 dec valid", 32'(decOutValid), 1);
      check("R7 enc valid", 32'(encOutValid), 1);
      check("R2 R9 expand", 32'(decSample), 32'(expDec(8'(i))));
      check("R4 R9 compress", 32'(encCode), 32'(expEnc(16'(i))));
    end

    // R3 zero codes
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      decCode = k == 0 ? 8'hFF : 8'h7F;
      @(posedge clk); #1;
      check("R3 zero code", 32'(decSample), 0);
    end

    // R5 R6 saturation corners
    for (int k = 0; k < 4; k++) begin
      logic [15:0] x;
      logic [7:0]  e;
      x = k == 0 ? 16'h7FFF : k == 1 ? 16'h8000 : k == 2 ? 16'd32636 : 16'hFFFF;
      e = k == 0 ? 8'h80 : k == 1 ? 8'h00 : k == 2 ? 8'h80 : 8'h7E;
      @(negedge clk); encSample = x;
      @(posedge clk); #1;
      check("R5 R6 corner", 32'(encCode), 32'(e));
    end

    // R10 round trip, expander running in the same cycle
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      decCode = 8'(c);
      encSample = expDec(8'(c));
      @(posedge clk); #1;
      check("R10 round trip", 32'(encCode), c == 8'h7F ? 32'hFF : 32'(c));
      check("R9 expander alongside", 32'(decSample), 32'(expDec(8'(c))));
    end

    // R8 hold
    heldDec = decSample; heldEnc = encCode;
    @(negedge clk);
    decValid = 1'b0; encValid = 1'b0;
    decCode = 8'h00; encSample = 16'h4000;
    repeat (3) begin
      @(posedge clk); #1;
      check("R8 dec hold", 32'(decSample), 32'(heldDec));
      check("R8 enc hold", 32'(encCode), 32'(heldEnc));
      check("R8 valids low", {decOutValid, encOutValid}, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule